// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A down-counting timer driven through a single-cycle register port. Software sets a reload value, a prescale divisor and a mode, then enables the counter. The counter steps down once per prescaled tick. When it reaches zero it raises a sticky event flag. In periodic mode it reloads on the tick after zero. In one-shot mode it parks at zero. Software clears the event flag by writing a one to it. A level interrupt output presents the flag whenever the interrupt enable is set.

The block fits under a bus bridge that issues one-cycle read and write strobes. Read data is registered and appears one clock after the read strobe. Writing the reload register also overwrites the live count. This lets software restart a period at any moment.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq` is low and `bus_rdata` is zero.
- R2: A read strobe returns data on `bus_rdata` one clock later, and zero in cycles without a read. Byte offset 0x08 (control) reads back run in bit 0, auto-reload in bit 1, interrupt enable in bit 2 and the prescale value in bits 15:8, with every other bit zero. Any offset other than 0x00, 0x04, 0x08 or 0x0C reads as zero.
- R3: A write to offset 0x00 sets the reload value and the live count in the same clock. Offset 0x04 returns the live count, and writes to it are ignored.
- R4: The count changes only while the run bit (control bit 0) is set, apart from reload-register writes.
- R5: With prescale value P (control bits 15:8) the count steps once every P+1 clocks. The first step comes P+1 clocks after run is set. The prescaler restarts from zero on every write to the reload register.
- R6: With auto-reload clear, the count stops at zero, and the event flag is set only on the step that reaches zero.
- R7: With auto-reload (control bit 1) set, a step taken at zero loads the reload value, which gives a period of reload+1 steps.
- R8: Status bit 0 (offset 0x0C) is set on the step that brings the count to zero. Writing 1 to it clears it, and writing 0 has no effect. A clear that arrives in the same clock as a new event loses to the event.
- R9: `irq` equals the event flag ANDed with the interrupt enable (control bit 2), and is valid in the same cycle as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Read data is due one edge after the read strobe, and `irq` follows the flag with no added delay. With prescale P, the n-th step after the enabling edge E lands on edge E+n(P+1). The bench drives all inputs on falling edges and samples on falling edges. Each counting run is frozen by a disabling write, and the bench counts that write's edge as a counting edge. It then reads the count and status while nothing moves, so the expected values depend only on how many edges the counter was enabled.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFS_RELOAD = 0;
  localparam int unsigned OFS_COUNT  = 4;
  localparam int unsigned OFS_CTRL   = 8;
  localparam int unsigned OFS_STATUS = 12;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_AUTO  = 1;
  localparam int unsigned BIT_IRQEN = 2;
  localparam int unsigned PRE_LSB   = 8;

  typedef struct packed {
    logic irq_en;
    logic auto_rl;
    logic run;
  } mode_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = run && (pcnt >= div);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pcnt <= '0;
    else if (pcnt >= div)       pcnt <= '0;
    else                        pcnt <= pcnt + 1'b1;
  end

  // R5: with a divisor above zero, two ticks never fall on adjacent clocks
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && !restart) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/tick_downcount.sv
module tick_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign hit = tick && !load_wr && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)                 count <= '0;
    else if (load_wr)        count <= load_val;
    else if (tick) begin
      if (count != '0)       count <= count - ONE;
      else if (auto_rl)      count <= reload;
    end
  end

  // R3: a reload write lands in the live count on the next clock
  a_r3_load_count: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (count == $past(load_val)));
  // R4: no tick and no load means the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_wr) |=> $stable(count));
  // R6: one-shot mode parks at zero
  a_r6_park_zero: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !auto_rl && !load_wr) |=> (count == '0));
  // R7: a step taken at zero in periodic mode reloads
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '0 && auto_rl && !load_wr) |=> (count == $past(reload)));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [DATA_W-1:0] count,
  output logic              load_wr,
  output logic [DATA_W-1:0] reload,
  output logic              run,
  output logic              auto_rl,
  output logic [PRE_W-1:0]  div,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  mode_t             mode_q, mode_d;
  logic              flag_q, flag_d;
  logic              ctrl_wr, stat_clr, known;
  logic [DATA_W-1:0] ctrl_view, rd_mux;

  always_comb begin
    load_wr  = wr_en && (addr == A_RELOAD);
    ctrl_wr  = wr_en && (addr == A_CTRL);
    stat_clr = wr_en && (addr == A_STATUS) && wdata[0];
    mode_d   = mode_q;
    if (ctrl_wr) begin
      mode_d.run     = wdata[BIT_RUN];
      mode_d.auto_rl = wdata[BIT_AUTO];
      mode_d.irq_en  = wdata[BIT_IRQEN];
    end
    flag_d = hit | (flag_q & ~stat_clr);
  end

  always_comb begin
    ctrl_view                     = '0;
    ctrl_view[BIT_RUN]            = mode_q.run;
    ctrl_view[BIT_AUTO]           = mode_q.auto_rl;
    ctrl_view[BIT_IRQEN]          = mode_q.irq_en;
    ctrl_view[PRE_LSB +: PRE_W]   = div;
    known  = 1'b1;
    rd_mux = '0;
    case (addr)
      A_RELOAD: rd_mux = reload;
      A_COUNT:  rd_mux = count;
      A_CTRL:   rd_mux = ctrl_view;
      A_STATUS: rd_mux = DATA_W'(flag_q);
      default:  known  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
      mode_q <= '0;
      div    <= '0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (load_wr) reload <= wdata;
      if (ctrl_wr) div    <= wdata[PRE_LSB +: PRE_W];
      mode_q <= mode_d;
      flag_q <= flag_d;
      irq    <= flag_d & mode_d.irq_en;
      rdata  <= rd_en ? rd_mux : '0;
    end
  end

  assign run     = mode_q.run;
  assign auto_rl = mode_q.auto_rl;

  // R2: unmapped offsets read as zero
  a_r2_unmapped: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !known) |=> (rdata == '0));
  // R8: an event always leaves the flag set
  a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  // R8: a write-one clear without an event drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !hit) |=> !flag_q);
  // R9: interrupt line tracks flag gated by enable
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q && mode_q.irq_en));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              load_wr, run, auto_rl, tick, hit;
  logic [DATA_W-1:0] reload, count;
  logic [PRE_W-1:0]  div;

  tick_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr), .wdata(bus_wdata),
    .rd_en(bus_rd), .hit(hit), .count(count), .load_wr(load_wr),
    .reload(reload), .run(run), .auto_rl(auto_rl), .div(div),
    .irq(irq), .rdata(bus_rdata)
  );

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .restart(load_wr), .div(div), .tick(tick)
  );

  tick_downcount #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load_wr(load_wr), .load_val(bus_wdata),
    .tick(tick), .auto_rl(auto_rl), .reload(reload), .count(count), .hit(hit)
  );
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam logic [7:0] A_RL = 8'h00, A_CT = 8'h04, A_CR = 8'h08, A_ST = 8'h0C;

  typedef struct packed {
    logic [7:0]  pre;
    logic [31:0] ld;
    logic        auto_rl;
    logic        ie;
    logic [15:0] cyc;
    logic [31:0] ecnt;
    logic        eflag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0,   32'd10, 1'b0, 1'b0, 16'd4,   32'd6, 1'b0},
    '{8'd3,   32'd10, 1'b0, 1'b1, 16'd12,  32'd7, 1'b0},
    '{8'd0,   32'd5,  1'b0, 1'b1, 16'd9,   32'd0, 1'b1},
    '{8'd0,   32'd5,  1'b1, 1'b0, 16'd7,   32'd4, 1'b1},
    '{8'd1,   32'd3,  1'b1, 1'b1, 16'd8,   32'd3, 1'b1},
    '{8'd2,   32'd4,  1'b0, 1'b1, 16'd11,  32'd1, 1'b0},
    '{8'd255, 32'd2,  1'b0, 1'b0, 16'd600, 32'd0, 1'b1},
    '{8'd4,   32'd7,  1'b1, 1'b1, 16'd20,  32'd3, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_RL, rv); chk("R1 reload", rv, 0);
    rd(A_CT, rv); chk("R1 count", rv, 0);
    rd(A_CR, rv); chk("R1 ctrl", rv, 0);
    rd(A_ST, rv); chk("R1 status", rv, 0);

    // Vector walk: R4 R5 R6 R7 R8 R9
    foreach (VECS[i]) begin
      wr(A_CR, 32'h0);
      wr(A_ST, 32'h1);
      wr(A_RL, VECS[i].ld);
      wr(A_CR, {16'h0, VECS[i].pre, 5'b0, VECS[i].ie, VECS[i].auto_rl, 1'b1});
      repeat (int'(VECS[i].cyc) - 1) @(negedge clk);
      wr(A_CR, {16'h0, VECS[i].pre, 5'b0, VECS[i].ie, VECS[i].auto_rl, 1'b0});
      rd(A_CT, rv); chk($sformatf("R5/R6/R7 vec%0d count", i), rv, VECS[i].ecnt);
      rd(A_ST, rv); chk($sformatf("R8 vec%0d flag", i), rv, {31'b0, VECS[i].eflag});
      chk($sformatf("R9 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].eflag & VECS[i].ie});
    end

    // R2 control readback drops unused bits
    wr(A_CR, 32'hFFFF_2AFE);
    rd(A_CR, rv); chk("R2 ctrl view", rv, 32'h0000_2A06);
    wr(A_CR, 32'h0);
    // R3 load, count write ignored; R4 hold while stopped
    wr(A_RL, 32'd9);
    rd(A_RL, rv); chk("R3 reload", rv, 9);
    wr(A_CT, 32'd55);
    rd(A_CT, rv); chk("R3 count write ignored", rv, 9);
    repeat (10) @(negedge clk);
    rd(A_CT, rv); chk("R4 hold while stopped", rv, 9);
    // R2 unmapped offsets
    rd(8'h10, rv); chk("R2 offset 0x10", rv, 0);
    rd(8'h06, rv); chk("R2 offset 0x06", rv, 0);
    chk("R2 idle rdata", bus_rdata, 0);

    // R5 prescaler restart on reload write
    wr(A_RL, 32'd20);
    wr(A_CR, 32'h0000_0301);
    repeat (5) @(negedge clk);
    wr(A_RL, 32'd8);
    repeat (5) @(negedge clk);
    wr(A_CR, 32'h0000_0300);
    rd(A_CT, rv); chk("R5 restart on load", rv, 7);

    // R6 one-shot flags once
    wr(A_CR, 32'h0); wr(A_ST, 32'h1);
    wr(A_RL, 32'd2);
    wr(A_CR, 32'h1);
    repeat (4) @(negedge clk);
    wr(A_ST, 32'h1);
    repeat (6) @(negedge clk);
    rd(A_ST, rv); chk("R6 no second event", rv, 0);
    rd(A_CT, rv); chk("R6 parked at zero", rv, 0);

    // R8 write 0 keeps flag, write 1 clears
    wr(A_CR, 32'h0);
    wr(A_RL, 32'd1);
    wr(A_CR, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_ST, 32'h0);
    rd(A_ST, rv); chk("R8 write 0 no effect", rv, 1);
    wr(A_ST, 32'h1);
    rd(A_ST, rv); chk("R8 write 1 clears", rv, 0);

    // R8 event beats simultaneous clear
    wr(A_CR, 32'h0);
    wr(A_RL, 32'd1);
    wr(A_CR, 32'h1);
    wr(A_ST, 32'h1);
    rd(A_ST, rv); chk("R8 event wins over clear", rv, 1);

    // R9 gating follows enable changes
    wr(A_CR, 32'h0);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(A_CR, 32'h4);
    chk("R9 irq on enable", {31'b0, irq}, 1);
    wr(A_ST, 32'h1);
    chk("R9 irq after clear", {31'b0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule